// File: doc/BRIEF.md
# Erasable Programmable Read-Only Memory Model

This block is a synthesizable behavioural model of a 4096-word by 8-bit memory that is cleared by an erase operation and written by timed programming pulses. It lets a memory-programmer or boot controller be verified against a device that behaves like the real part. A single active-low strobe pin serves two purposes. When the programming-voltage flag is absent, the strobe selects between reading and power-down. When the flag is present, a high-to-low pulse on the strobe programs the addressed word. Erased cells read as one, and programming can only turn ones into zeros.

The data bus is split into an input path and an output path. An output-enable flag stands in for tri-state pins, so a bench can see exactly when the model would drive the bus. A pulse-width checker counts the clock cycles of each programming pulse against a minimum of 9 ms and a maximum of 44 ms, both scaled by a cycles-per-millisecond parameter. It reports pulses that break these limits on an error flag.

The pulse tracker is a three-state machine:
- ST_READY: waits for a pulse.
- ST_PULSE: counts the strobe-low cycles.
- ST_OVERRUN: the pulse has gone past the maximum width.

Its transitions are:
- READY→PULSE (start): a falling strobe while the voltage flag is set.
- PULSE→PULSE (count): the strobe is still low and the width is within the maximum.
- PULSE→READY (release): the strobe goes high. The word is written if the width is legal.
- PULSE→READY (abort): the voltage flag drops during the pulse.
- PULSE→OVERRUN (overlong): the strobe is still low after the maximum-width count.
- OVERRUN→READY (release or abort): the strobe goes high or the voltage flag drops.

Top module: `eprom_model`

## Requirements
- R1: The array holds 4096 independent 8-bit words selected by the 12-bit `addr`. Words can be programmed in any order, and programming one word leaves every other word unchanged.
- R2: After reset, and from the cycle after `erase` is sampled high, every word reads 8'hFF. The erase takes one clock cycle. If a pulse commits in the same cycle as an erase, the erase wins and the commit is discarded.
- R3: With `vpp_on` low and `strobe` low, `dout_en` is 1 and `dout` shows the addressed word in the same cycle. With `vpp_on` low and `strobe` high, `dout_en` is 0 and `dout` is 8'h00.
- R4: A legal programming pulse stores old & din at the address. Both `addr` and `din` are captured at the first clock edge that samples `strobe` low. Zeros never return to one except through erase.
- R5: While `vpp_on` is high, `dout_en` is 0 whatever the level of `strobe`. When `strobe` is held high, no word changes.
- R6: `mode` encodes the decoded mode: 0 is read, 1 is power-down (`vpp_on` low, `strobe` high), 2 is program (`vpp_on` high, `strobe` low), and 3 is inhibit (`vpp_on` high, `strobe` high).
- R7: Pulse width is the number of clock edges at which `strobe` is sampled low. A width from MIN = 9×CYCLES_PER_MS to MAX = 44×CYCLES_PER_MS is legal: the word is written at the release edge and `pulse_err` is cleared. A shorter pulse writes nothing and sets `pulse_err`. At the (MAX+1)th low sample, `pulse_err` is set, and nothing is written when the strobe is later released.
- R8: If `vpp_on` drops while a pulse is being counted, the pulse is aborted: nothing is written and `pulse_err` is set.
- R9: A pulse starts only on a high-to-low transition of `strobe` seen while `vpp_on` is high. If `strobe` is already low when `vpp_on` rises, nothing is written and `pulse_err` does not change.
- R10: Reset clears `pulse_err` and returns the state machine to ST_READY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Word address |
| din | input | 8 | Data presented for programming |
| dout | output | 8 | Read data (zero when not enabled) |
| dout_en | output | 1 | High when the model would drive the bus |
| strobe | input | 1 | Power-down (high) / read select (low) / program pulse (falling) |
| vpp_on | input | 1 | Programming voltage present |
| erase | input | 1 | Return every bit to one |
| mode | output | 2 | Decoded mode code |
| pulse_err | output | 1 | Last programming pulse was out of range or aborted |

## Verification
Random programming pulses of legal width are aimed at a small pool of addresses, so the same words are programmed repeatedly with random data. This separates the required AND behaviour from a plain overwrite. Random short pulses are interleaved with them, so a rejected pulse can be distinguished from one that was accepted. Directed cases cover:
- pulses at exactly MIN−1, MIN, MAX and MAX+1 cycles, which expose off-by-one errors in the width counter;
- a voltage drop in mid-pulse;
- a strobe that is already low when the voltage rises;
- an erase that coincides with a commit;
- the first and last addresses, which show that words are independent.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [1:0] {
        MODE_READ      = 2'd0,
        MODE_POWERDOWN = 2'd1,
        MODE_PROGRAM   = 2'd2,
        MODE_INHIBIT   = 2'd3
    } eprom_mode_e;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_PULSE   = 2'd1,
        ST_OVERRUN = 2'd2
    } pulse_state_e;

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic        vpp_on,
    input  logic        strobe,
    output eprom_mode_e mode,
    output logic        drive_en
);

    always_comb begin
        unique case ({vpp_on, strobe})
            2'b00:   mode = MODE_READ;
            2'b01:   mode = MODE_POWERDOWN;
            2'b10:   mode = MODE_PROGRAM;
            default: mode = MODE_INHIBIT;
        endcase
        drive_en = (mode == MODE_READ);
    end

endmodule

// File: rtl/eprom_pulse_fsm.sv
module eprom_pulse_fsm
    import eprom_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 8,
    parameter int CYCLES_PER_MS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vpp_on,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              pulse_err
);

    localparam int MIN_CYC = 9 * CYCLES_PER_MS;
    localparam int MAX_CYC = 44 * CYCLES_PER_MS;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_CYC);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CYC);

    pulse_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              err_q, err_d;
    logic              strobe_prev;
    logic              capture;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_READY;
            cnt_q       <= '0;
            err_q       <= 1'b0;
            strobe_prev <= 1'b1;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            state_q     <= state_d;
            cnt_q       <= cnt_d;
            err_q       <= err_d;
            strobe_prev <= strobe;
            if (capture) begin
                wr_addr <= addr;
                wr_data <= din;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        err_d   = err_q;
        commit  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (vpp_on && strobe_prev && !strobe) begin
                    state_d = ST_PULSE;
                    cnt_d   = CNT_W'(1);
                    capture = 1'b1;
                end
            end
            ST_PULSE: begin
                if (!vpp_on) begin
                    state_d = ST_READY;
                    err_d   = 1'b1;
                end else if (!strobe) begin
                    if (cnt_q == MAX_C) begin
                        state_d = ST_OVERRUN;
                        err_d   = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end else begin
                    state_d = ST_READY;
                    if (cnt_q >= MIN_C) begin
                        commit = 1'b1;
                        err_d  = 1'b0;
                    end else begin
                        err_d  = 1'b1;
                    end
                end
            end
            ST_OVERRUN: begin
                if (!vpp_on || strobe) state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
    end

    assign pulse_err = err_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> (cnt_q <= MAX_C && cnt_q != '0)); // R7
    AST_OVERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OVERRUN) |-> pulse_err); // R7
    AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !vpp_on) |=> (pulse_err && state_q == ST_READY)); // R8
    AST_NO_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && !strobe_prev) |=> (state_q == ST_READY)); // R9

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  touched;
    logic [DATA_W-1:0] old_word;
    logic              do_write;

    assign do_write = commit && !erase;
    assign old_word = touched[wr_addr] ? cells[wr_addr] : '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            touched <= '0;
        end else if (erase) begin
            touched <= '0;
        end else if (do_write) begin
            touched[wr_addr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_write) cells[wr_addr] <= old_word & wr_data;
    end

    assign rd_data = touched[rd_addr] ? cells[rd_addr] : '1;

endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 8,
    parameter int CYCLES_PER_MS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    input  logic              strobe,
    input  logic              vpp_on,
    input  logic              erase,
    output logic [1:0]        mode,
    output logic              pulse_err
);

    eprom_mode_e       mode_e;
    logic              drive_en;
    logic              commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    eprom_mode_decode u_decode (
        .vpp_on   (vpp_on),
        .strobe   (strobe),
        .mode     (mode_e),
        .drive_en (drive_en)
    );

    eprom_pulse_fsm #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .CYCLES_PER_MS (CYCLES_PER_MS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vpp_on    (vpp_on),
        .strobe    (strobe),
        .addr      (addr),
        .din       (din),
        .commit    (commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pulse_err (pulse_err)
    );

    eprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .commit  (commit),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    assign mode    = mode_e;
    assign dout_en = drive_en;
    assign dout    = drive_en ? rd_data : '0;

    AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!vpp_on && !strobe)); // R3
    AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(erase) && dout_en) |-> (dout == '1)); // R2
    AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(commit && !erase) && dout_en && addr == $past(wr_addr))
        |-> ((dout & ~$past(wr_data)) == '0)); // R4
    AST_HIGHV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_on |-> !dout_en); // R5

endmodule

// File: tb/tb_eprom_model.sv
module tb_eprom_model;

    localparam int CLK_PERIOD = 10;
    localparam int MINW = 9;
    localparam int MAXW = 44;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        strobe = 1'b1;
    logic        vpp_on = 1'b0;
    logic        erase = 1'b0;
    logic [1:0]  mode;
    logic        pulse_err;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [0:4095];
    logic       ref_err;

    eprom_model dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .strobe(strobe), .vpp_on(vpp_on), .erase(erase),
        .mode(mode), .pulse_err(pulse_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit width_ok(input int w);
        return (w >= MINW) && (w <= MAXW);
    endfunction

    function automatic logic [1:0] ref_mode(input logic v, input logic s);
        return v ? (s ? 2'd3 : 2'd2) : (s ? 2'd1 : 2'd0);
    endfunction

    task automatic ref_erase();
        for (int i = 0; i < 4096; i++) ref_mem[i] = 8'hFF;
    endtask

    task automatic read_check(input logic [11:0] a, input string req);
        @(negedge clk);
        vpp_on = 1'b0; strobe = 1'b0; addr = a;
        #1;
        chk(dout_en === 1'b1, req, {31'd0, dout_en}, 32'd1);
        chk(dout === ref_mem[a], req, {24'd0, dout}, {24'd0, ref_mem[a]});
        @(negedge clk);
        strobe = 1'b1;
    endtask

    // Program pulse of w low samples; updates reference model
    task automatic pulse(input logic [11:0] a, input logic [7:0] d, input int w,
                         input bit erase_at_release);
        @(negedge clk);
        vpp_on = 1'b1; strobe = 1'b1; addr = a; din = d;
        @(negedge clk);
        strobe = 1'b0;
        #1;
        chk(mode === 2'd2 && dout_en === 1'b0, "R5 R6 program mode",
            {29'd0, dout_en, mode}, 32'd2);
        repeat (w) @(negedge clk);
        addr = ~a; din = 8'h00;
        strobe = 1'b1;
        erase = erase_at_release;
        @(negedge clk);
        erase = 1'b0;
        if (erase_at_release) ref_erase();
        else if (width_ok(w)) ref_mem[a] = ref_mem[a] & d;
        ref_err = !width_ok(w);
        #1;
        chk(pulse_err === ref_err, "R7 pulse_err", {31'd0, pulse_err}, {31'd0, ref_err});
        vpp_on = 1'b0;
    endtask

    initial begin
        int seed;
        logic [11:0] pool [0:7];
        seed = int'($urandom(32'h1234ABCD));
        ref_erase();
        ref_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(pulse_err === 1'b0, "R10 reset err", {31'd0, pulse_err}, 32'd0);
        chk(mode === 2'd1 && dout_en === 1'b0, "R3 R6 powerdown",
            {29'd0, dout_en, mode}, 32'd1);
        chk(dout === 8'h00, "R3 disabled dout", {24'd0, dout}, 32'd0);
        read_check(12'h000, "R2 reset reads ones");
        read_check(12'hFFF, "R2 reset reads ones");

        // R1: first and last words independent
        pulse(12'h000, 8'hA5, 10, 1'b0);
        pulse(12'hFFF, 8'h3C, 10, 1'b0);
        read_check(12'h000, "R1 word 0");
        read_check(12'hFFF, "R1 word 4095");
        read_check(12'h001, "R1 neighbour");
        // R4: AND behaviour, zeros stay
        pulse(12'h000, 8'h0F, MINW, 1'b0);
        read_check(12'h000, "R4 and-in");
        pulse(12'h000, 8'hFF, MAXW, 1'b0);
        read_check(12'h000, "R4 no zero-to-one");

        // R7 boundaries
        pulse(12'h010, 8'h00, MINW - 1, 1'b0);
        read_check(12'h010, "R7 short pulse no write");
        pulse(12'h011, 8'h00, MAXW + 1, 1'b0);
        read_check(12'h011, "R7 overlong no write");
        pulse(12'h012, 8'h77, MINW, 1'b0);
        read_check(12'h012, "R7 min width writes");

        // R8: abort by vpp drop
        @(negedge clk);
        vpp_on = 1'b1; strobe = 1'b1; addr = 12'h020; din = 8'h00;
        @(negedge clk);
        strobe = 1'b0;
        repeat (12) @(negedge clk);
        vpp_on = 1'b0;
        @(negedge clk);
        strobe = 1'b1;
        #1;
        chk(pulse_err === 1'b1, "R8 abort err", {31'd0, pulse_err}, 32'd1);
        read_check(12'h020, "R8 abort no write");

        // clear err with a legal pulse, then R9
        pulse(12'h030, 8'hF0, 20, 1'b0);
        @(negedge clk);
        vpp_on = 1'b0; strobe = 1'b0; addr = 12'h031; din = 8'h00;
        @(negedge clk);
        vpp_on = 1'b1;
        repeat (15) @(negedge clk);
        strobe = 1'b1;
        #1;
        chk(mode === 2'd3 && dout_en === 1'b0, "R5 R6 inhibit",
            {29'd0, dout_en, mode}, 32'd3);
        repeat (5) @(negedge clk);
        vpp_on = 1'b0;
        #1;
        chk(pulse_err === 1'b0, "R9 err unchanged", {31'd0, pulse_err}, 32'd0);
        read_check(12'h031, "R9 no pulse without falling edge");

        // R2: erase beats same-cycle commit
        pulse(12'h040, 8'h00, 15, 1'b1);
        read_check(12'h040, "R2 erase wins");
        read_check(12'h000, "R2 erase clears");
        read_check(12'hFFF, "R2 erase clears");

        // random phase
        for (int i = 0; i < 8; i++) pool[i] = 12'($urandom);
        for (int it = 0; it < 60; it++) begin
            int op;
            logic [11:0] a;
            op = int'($urandom % 4);
            a = pool[$urandom % 8];
            if (op <= 1)
                pulse(a, 8'($urandom), MINW + int'($urandom % (MAXW - MINW + 1)), 1'b0);
            else if (op == 2)
                read_check(a, "R4 random readback");
            else
                pulse(a, 8'($urandom), 1 + int'($urandom % (MINW - 1)), 1'b0);
        end
        for (int i = 0; i < 8; i++) read_check(pool[i], "R1 R4 final pool");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule